// File: doc/BRIEF.md
# Register Renamer with Sequence-Ordered Undo Log

This block translates architectural register numbers into physical register numbers for an out-of-order pipeline. It keeps a mapping table (one physical register per architectural register), a pool of unallocated physical registers, a ready flag for every physical register, and a circular log of rename records ordered by instruction sequence number. An instruction that writes a register asks for a rename. The block then takes a free physical register, points the architectural register at it, and returns both the new register and the one it displaced. An instruction with no destination still leaves a record that holds only its sequence number.

Retirement and misprediction recovery both run through the log. A commit names a sequence number. If the oldest record carries that number, the record is retired and the register it displaced goes back to the pool. A squash names the youngest sequence number that survives. The block then walks back from the young end of the log, one record per cycle, until it reaches that number. For each record it undoes, it restores the old mapping and releases the newly allocated register. Source operands are looked up combinationally, and each lookup returns the physical register together with its ready flag. The ready flags are set through a simple write port.

Top module: `reg_renamer`

## Requirements
- R1: After reset, architectural register i maps to physical register i and every physical register reads as ready. The free count equals NUM_PHYS − NUM_ARCH.
- R2: An accepted rename with a destination returns the lowest-numbered free physical register on `ren_new_phys` and the current mapping of `ren_arch` on `ren_prev_phys`. From the next cycle, lookups of that architectural register return the new register with ready = 0, and the free count is one lower.
- R3: A source lookup returns, in the same cycle, the mapped physical register of `src_arch` and its ready flag. A pulse on `rdy_set_valid` makes `rdy_set_phys` read as ready from the next cycle.
- R4: An accepted rename with `ren_has_dst` = 0 takes one log slot and leaves the mapping and the free count unchanged. The log holds at most HIST_DEPTH records.
- R5: A commit whose sequence number equals that of the oldest record retires that record. If the record is not a placeholder, its displaced register is returned and the free count rises by one from the next cycle. A commit with any other sequence number, or sent while the log is empty, has no effect.
- R6: A squash raises `busy` from the next cycle. In each busy cycle the youngest record is undone while its sequence number is greater than `sq_seq`: the mapping is restored to the displaced register and the new register is freed. `busy` falls one cycle after the last record is undone, so a walk that undoes N records keeps `busy` high for N+1 cycles. A squash sent while the log is empty changes nothing.
- R7: `ren_stall` is high while `busy` or `sq_valid` is high, while the log is full, or when a destination is requested and no free register exists. A refused rename changes no state, and `ren_accept` = `ren_valid` and not `ren_stall`.
- R8: A commit sent while `busy` or `sq_valid` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_arch | input | clog2(NUM_ARCH) | Architectural register to look up |
| src_phys | output | clog2(NUM_PHYS) | Current mapping of `src_arch` |
| src_ready | output | 1 | Ready flag of `src_phys` |
| ren_valid | input | 1 | Rename request |
| ren_has_dst | input | 1 | Request writes a destination (0 = placeholder) |
| ren_arch | input | clog2(NUM_ARCH) | Destination architectural register |
| ren_seq | input | SEQ_W | Sequence number of the requesting instruction |
| ren_stall | output | 1 | Rename cannot be taken this cycle |
| ren_accept | output | 1 | Rename taken this cycle |
| ren_new_phys | output | clog2(NUM_PHYS) | Physical register allocated |
| ren_prev_phys | output | clog2(NUM_PHYS) | Physical register displaced |
| cmt_valid | input | 1 | Commit notification |
| cmt_seq | input | SEQ_W | Sequence number being committed |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Youngest surviving sequence number |
| busy | output | 1 | Squash walk in progress |
| rdy_set_valid | input | 1 | Mark a physical register ready |
| rdy_set_phys | input | clog2(NUM_PHYS) | Register to mark ready |
| free_count | output | clog2(NUM_PHYS+1) | Number of free physical registers |

## Verification
Most faults in the pool, the mapping table or the log reach `free_count` or a source lookup in the cycle after the edge that corrupted them. The allocation ports expose a lost or duplicated free register on the next rename. A log pointer that walks too far or not far enough misplaces the mapping only after the squash ends. It also ends `busy` a cycle early or late, which the N+1 rule makes visible at once. Commits that are mis-ordered or wrongly accepted do not show until the displaced register returns to the pool, so every cycle compares the free count against the bench's own model of pool and log.

// File: rtl/rr_pkg.sv
// Package: default configuration shared by the renamer and its bench.
// Assumes the physical register count exceeds the architectural count and
// that the log depth is a power of two.
package rr_pkg;
    parameter int DEF_ARCH  = 8;
    parameter int DEF_PHYS  = 16;
    parameter int DEF_HIST  = 16;
    parameter int DEF_SEQ_W = 16;
endpackage

// File: rtl/rr_freelist.sv
// Pool of unallocated physical registers, held as a bit vector.
// Allocation hands out the lowest-numbered free register. Two release ports
// (commit and squash) may free registers in the same cycle as an allocation.
// Assumes a released register is not currently free.
module rr_freelist #(
    parameter int NP = 16,
    parameter int NA = 8,
    parameter int PW = 4,
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_en,
    input  logic          rel_a_en,
    input  logic [PW-1:0] rel_a_idx,
    input  logic          rel_b_en,
    input  logic [PW-1:0] rel_b_idx,
    output logic [PW-1:0] alloc_idx,
    output logic          empty,
    output logic [CW-1:0] count
);
    logic [NP-1:0] free_q, free_d;

    // Next pool contents: clear the allocated bit, set released bits.
    always_comb begin
        free_d = free_q;
        if (alloc_en) free_d[alloc_idx] = 1'b0;
        if (rel_a_en) free_d[rel_a_idx] = 1'b1;
        if (rel_b_en) free_d[rel_b_idx] = 1'b1;
    end

    // Pool register: registers above the architectural range start free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NP; i++) free_q[i] <= (i >= NA);
        end else begin
            free_q <= free_d;
        end
    end

    // Lowest-index priority pick.
    always_comb begin
        alloc_idx = '0;
        for (int i = NP - 1; i >= 0; i--)
            if (free_q[i]) alloc_idx = PW'(i);
    end

    // Population count of the pool.
    always_comb begin
        count = '0;
        for (int i = 0; i < NP; i++) count = count + CW'(free_q[i]);
    end

    assign empty = ~|free_q;
endmodule

// File: rtl/rr_maptable.sv
// Architectural-to-physical mapping table plus per-physical ready flags.
// Two read ports: one for source lookup (with ready), one for the
// destination's displaced register. One write port shared by rename and
// squash restore, which never act in the same cycle.
module rr_maptable #(
    parameter int NA = 8,
    parameter int NP = 16,
    parameter int AW = 3,
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] src_arch,
    output logic [PW-1:0] src_phys,
    output logic          src_ready,
    input  logic [AW-1:0] dst_arch,
    output logic [PW-1:0] dst_prev,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_arch,
    input  logic [PW-1:0] wr_phys,
    input  logic          clr_en,
    input  logic [PW-1:0] clr_idx,
    input  logic          set_en,
    input  logic [PW-1:0] set_idx
);
    logic [PW-1:0] map_q [NA];
    logic [NP-1:0] rdy_q;

    // Mapping table: identity at reset, one write per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NA; i++) map_q[i] <= PW'(i);
        end else if (wr_en) begin
            map_q[wr_arch] <= wr_phys;
        end
    end

    // Ready flags: all set at reset, cleared on allocation, set by write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_q <= '1;
        end else begin
            if (clr_en) rdy_q[clr_idx] <= 1'b0;
            if (set_en) rdy_q[set_idx] <= 1'b1;
        end
    end

    assign src_phys  = map_q[src_arch];
    assign src_ready = rdy_q[src_phys];
    assign dst_prev  = map_q[dst_arch];
endmodule

// File: rtl/rr_history.sv
// Circular log of rename records. Pushes go to the young end (head); the
// squash walk pops from the young end, commit pops from the old end (tail).
// Assumes HD is a power of two, that a young pop never coincides with a push
// or an old pop, and that the caller never pushes when full or pops when empty.
module rr_history #(
    parameter int HD  = 16,
    parameter int SW  = 16,
    parameter int AW  = 3,
    parameter int PW  = 4,
    parameter int HCW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push_en,
    input  logic [SW-1:0]  push_seq,
    input  logic [AW-1:0]  push_arch,
    input  logic [PW-1:0]  push_new,
    input  logic [PW-1:0]  push_prev,
    input  logic           push_has,
    input  logic           pop_young,
    input  logic           pop_old,
    output logic [SW-1:0]  y_seq,
    output logic [AW-1:0]  y_arch,
    output logic [PW-1:0]  y_new,
    output logic [PW-1:0]  y_prev,
    output logic           y_has,
    output logic [SW-1:0]  o_seq,
    output logic [PW-1:0]  o_prev,
    output logic           o_has,
    output logic [HCW-1:0] count
);
    localparam int HPW = $clog2(HD);

    typedef struct packed {
        logic [SW-1:0] seq;
        logic [AW-1:0] arch;
        logic [PW-1:0] newp;
        logic [PW-1:0] prevp;
        logic          has;
    } rec_t;

    rec_t           mem_q [HD];
    logic [HPW-1:0] head_q, tail_q, young_idx;
    rec_t           yrec, orec;

    // Record storage: written at the head slot on push.
    always_ff @(posedge clk) begin
        if (push_en) mem_q[head_q] <= '{push_seq, push_arch, push_new, push_prev, push_has};
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            count  <= '0;
        end else begin
            if (push_en)        head_q <= head_q + HPW'(1);
            else if (pop_young) head_q <= head_q - HPW'(1);
            if (pop_old)        tail_q <= tail_q + HPW'(1);
            count <= count + HCW'(push_en) - HCW'(pop_young) - HCW'(pop_old);
        end
    end

    assign young_idx = head_q - HPW'(1);
    assign yrec      = mem_q[young_idx];
    assign orec      = mem_q[tail_q];
    assign y_seq     = yrec.seq;
    assign y_arch    = yrec.arch;
    assign y_new     = yrec.newp;
    assign y_prev    = yrec.prevp;
    assign y_has     = yrec.has;
    assign o_seq     = orec.seq;
    assign o_prev    = orec.prevp;
    assign o_has     = orec.has;
endmodule

// File: rtl/reg_renamer.sv
// Register renamer top: ties together the mapping table, the free pool and
// the undo log, and sequences commit, rename and the one-record-per-cycle
// squash walk. Assumes sequence numbers increase with program order and do
// not wrap while records are live.
module reg_renamer #(
    parameter int NUM_ARCH   = rr_pkg::DEF_ARCH,
    parameter int NUM_PHYS   = rr_pkg::DEF_PHYS,
    parameter int HIST_DEPTH = rr_pkg::DEF_HIST,
    parameter int SEQ_W      = rr_pkg::DEF_SEQ_W,
    localparam int AW  = $clog2(NUM_ARCH),
    localparam int PW  = $clog2(NUM_PHYS),
    localparam int CW  = $clog2(NUM_PHYS + 1),
    localparam int HCW = $clog2(HIST_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    src_arch,
    output logic [PW-1:0]    src_phys,
    output logic             src_ready,
    input  logic             ren_valid,
    input  logic             ren_has_dst,
    input  logic [AW-1:0]    ren_arch,
    input  logic [SEQ_W-1:0] ren_seq,
    output logic             ren_stall,
    output logic             ren_accept,
    output logic [PW-1:0]    ren_new_phys,
    output logic [PW-1:0]    ren_prev_phys,
    input  logic             cmt_valid,
    input  logic [SEQ_W-1:0] cmt_seq,
    input  logic             sq_valid,
    input  logic [SEQ_W-1:0] sq_seq,
    output logic             busy,
    input  logic             rdy_set_valid,
    input  logic [PW-1:0]    rdy_set_phys,
    output logic [CW-1:0]    free_count
);
    logic [SEQ_W-1:0] bound_q;
    logic [PW-1:0]    alloc_idx, dst_prev;
    logic             pool_empty;
    logic [HCW-1:0]   hist_cnt;
    logic             hist_full, hist_empty;
    logic [SEQ_W-1:0] y_seq, o_seq;
    logic [AW-1:0]    y_arch;
    logic [PW-1:0]    y_new, y_prev, o_prev;
    logic             y_has, o_has;
    logic             do_walk, walk_done, cmt_ok, alloc_en, undo_map;

    assign hist_full  = (hist_cnt == HCW'(HIST_DEPTH));
    assign hist_empty = (hist_cnt == '0);

    // Control decisions for this cycle.
    always_comb begin
        do_walk    = busy && !sq_valid && !hist_empty && (y_seq > bound_q);
        walk_done  = busy && !sq_valid && !do_walk;
        ren_stall  = busy || sq_valid || hist_full || (ren_has_dst && pool_empty);
        ren_accept = ren_valid && !ren_stall;
        alloc_en   = ren_accept && ren_has_dst;
        undo_map   = do_walk && y_has;
        cmt_ok     = cmt_valid && !busy && !sq_valid && !hist_empty && (o_seq == cmt_seq);
    end

    // Squash walk state: latch the surviving bound, clear when walk ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            bound_q <= '0;
        end else if (sq_valid) begin
            busy    <= 1'b1;
            bound_q <= sq_seq;
        end else if (walk_done) begin
            busy    <= 1'b0;
        end
    end

    assign ren_new_phys  = alloc_idx;
    assign ren_prev_phys = dst_prev;

    rr_maptable #(.NA(NUM_ARCH), .NP(NUM_PHYS), .AW(AW), .PW(PW)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_arch (src_arch),
        .src_phys (src_phys),
        .src_ready(src_ready),
        .dst_arch (ren_arch),
        .dst_prev (dst_prev),
        .wr_en    (alloc_en || undo_map),
        .wr_arch  (undo_map ? y_arch : ren_arch),
        .wr_phys  (undo_map ? y_prev : alloc_idx),
        .clr_en   (alloc_en),
        .clr_idx  (alloc_idx),
        .set_en   (rdy_set_valid),
        .set_idx  (rdy_set_phys)
    );

    rr_freelist #(.NP(NUM_PHYS), .NA(NUM_ARCH), .PW(PW), .CW(CW)) u_pool (
        .clk      (clk),
        .rst_n    (rst_n),
        .alloc_en (alloc_en),
        .rel_a_en (cmt_ok && o_has),
        .rel_a_idx(o_prev),
        .rel_b_en (undo_map),
        .rel_b_idx(y_new),
        .alloc_idx(alloc_idx),
        .empty    (pool_empty),
        .count    (free_count)
    );

    rr_history #(.HD(HIST_DEPTH), .SW(SEQ_W), .AW(AW), .PW(PW), .HCW(HCW)) u_log (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_en  (ren_accept),
        .push_seq (ren_seq),
        .push_arch(ren_arch),
        .push_new (alloc_idx),
        .push_prev(dst_prev),
        .push_has (ren_has_dst),
        .pop_young(do_walk),
        .pop_old  (cmt_ok),
        .y_seq    (y_seq),
        .y_arch   (y_arch),
        .y_new    (y_new),
        .y_prev   (y_prev),
        .y_has    (y_has),
        .o_seq    (o_seq),
        .o_prev   (o_prev),
        .o_has    (o_has),
        .count    (hist_cnt)
    );
endmodule

// File: rtl/rr_checker.sv
// Property checker for reg_renamer, attached by bind below.
module rr_checker #(
    parameter int NUM_ARCH   = 8,
    parameter int NUM_PHYS   = 16,
    parameter int HIST_DEPTH = 16,
    parameter int PW  = 4,
    parameter int CW  = 5,
    parameter int HCW = 5
) (
    input logic           clk,
    input logic           rst_n,
    input logic           busy,
    input logic           sq_valid,
    input logic           ren_accept,
    input logic           ren_has_dst,
    input logic [PW-1:0]  ren_new_phys,
    input logic [PW-1:0]  ren_prev_phys,
    input logic [CW-1:0]  free_count,
    input logic [HCW-1:0] hist_cnt
);
    // R1: the mapped set always holds NUM_ARCH registers, so the pool never exceeds the rest
    assert_pool_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        free_count <= CW'(NUM_PHYS - NUM_ARCH));

    // R2: an allocated register differs from the one it displaces
    assert_fresh_reg_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_accept && ren_has_dst) |-> (ren_new_phys != ren_prev_phys));

    // R4: the log never holds more than its depth
    assert_log_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hist_cnt <= HCW'(HIST_DEPTH));

    // R6: a squash request starts the walk on the next cycle
    assert_walk_starts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sq_valid |=> busy);

    // R7: no allocation while walking, so the pool cannot shrink
    assert_no_alloc_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (free_count >= $past(free_count)));
endmodule

bind reg_renamer rr_checker #(
    .NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .HIST_DEPTH(HIST_DEPTH),
    .PW(PW), .CW(CW), .HCW(HCW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .sq_valid(sq_valid),
    .ren_accept(ren_accept), .ren_has_dst(ren_has_dst),
    .ren_new_phys(ren_new_phys), .ren_prev_phys(ren_prev_phys),
    .free_count(free_count), .hist_cnt(hist_cnt)
);

// File: tb/reg_renamer_test.sv
`timescale 1ns/1ps
module reg_renamer_test;
    localparam int NA = 8, NP = 16, HD = 16, SW = 16;
    localparam int AW = $clog2(NA), PW = $clog2(NP), CW = $clog2(NP + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic [AW-1:0] src_arch = '0, ren_arch = '0;
    logic [PW-1:0] src_phys, ren_new_phys, ren_prev_phys, rdy_set_phys = '0;
    logic src_ready, ren_valid = 0, ren_has_dst = 0, ren_stall, ren_accept;
    logic [SW-1:0] ren_seq = '0, cmt_seq = '0, sq_seq = '0;
    logic cmt_valid = 0, sq_valid = 0, busy, rdy_set_valid = 0;
    logic [CW-1:0] free_count;

    always #2.5 clk = ~clk;

    reg_renamer #(.NUM_ARCH(NA), .NUM_PHYS(NP), .HIST_DEPTH(HD), .SEQ_W(SW)) uut (.*);

    typedef struct { int seq; bit has; int arch; int newp; int prevp; } hrec_t;
    hrec_t hq[$];
    int  map_m [NA];
    bit  rdy_m [NP];
    bit  free_m[NP];
    int  seqc = 1;
    int  total = 0, bad = 0;
    bit  done = 0;

    function automatic int low_free();
        for (int i = 0; i < NP; i++) if (free_m[i]) return i;
        return -1;
    endfunction

    function automatic int nfree();
        int n = 0;
        for (int i = 0; i < NP; i++) n += free_m[i];
        return n;
    endfunction

    task automatic chk(string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic drive_idle();
        ren_valid = 0; ren_has_dst = 0; cmt_valid = 0; sq_valid = 0; rdy_set_valid = 0;
        src_arch = AW'($urandom % NA);
    endtask

    task automatic check_common(string tag);
        chk({tag, " free_count"}, int'(free_count), nfree());
        chk("R3 src_phys", int'(src_phys), map_m[src_arch]);
        chk("R3 src_ready", int'(src_ready), int'(rdy_m[map_m[src_arch]]));
    endtask

    task automatic do_idle(int a, string tag);
        @(negedge clk); drive_idle(); src_arch = AW'(a);
        #1 check_common(tag);
        @(posedge clk);
    endtask

    task automatic do_rename(bit has, int arch, string tag);
        bit exp_stall;
        int np;
        hrec_t r;
        @(negedge clk); drive_idle();
        ren_valid = 1; ren_has_dst = has; ren_arch = AW'(arch); ren_seq = SW'(seqc);
        #1;
        exp_stall = (hq.size() == HD) || (has && low_free() < 0);
        chk({tag, " ren_stall"}, int'(ren_stall), int'(exp_stall));
        chk("R7 ren_accept", int'(ren_accept), int'(!exp_stall));
        check_common("R2");
        if (!exp_stall && has) begin
            chk("R2 new_phys", int'(ren_new_phys), low_free());
            chk("R2 prev_phys", int'(ren_prev_phys), map_m[arch]);
        end
        @(posedge clk); #1;
        if (!exp_stall) begin
            r.seq = seqc; r.has = has; r.arch = arch; r.newp = 0; r.prevp = 0;
            if (has) begin
                np = low_free();
                free_m[np] = 0; rdy_m[np] = 0;
                r.newp = np; r.prevp = map_m[arch];
                map_m[arch] = np;
            end
            hq.push_back(r);
            seqc++;
        end
    endtask

    task automatic do_commit(int s, string tag);
        @(negedge clk); drive_idle();
        cmt_valid = 1; cmt_seq = SW'(s);
        #1 check_common(tag);
        @(posedge clk); #1;
        if (hq.size() > 0 && hq[0].seq == s) begin
            if (hq[0].has) free_m[hq[0].prevp] = 1;
            void'(hq.pop_front());
        end
    endtask

    task automatic do_rdy(int p);
        @(negedge clk); drive_idle();
        rdy_set_valid = 1; rdy_set_phys = PW'(p);
        #1 check_common("R3");
        @(posedge clk); #1;
        rdy_m[p] = 1;
    endtask

    task automatic do_squash(int b);
        int pops = 0;
        hrec_t r;
        @(negedge clk); drive_idle();
        sq_valid = 1; sq_seq = SW'(b); ren_valid = 1; ren_has_dst = 0;
        #1;
        chk("R7 stall on squash", int'(ren_stall), 1);
        check_common("R6");
        @(posedge clk);
        for (int i = hq.size() - 1; i >= 0; i--) begin
            if (hq[i].seq > b) pops++;
            else break;
        end
        for (int k = 0; k <= pops; k++) begin
            @(negedge clk); drive_idle();
            ren_valid = 1; ren_has_dst = 0;
            if (hq.size() > 0) begin cmt_valid = 1; cmt_seq = SW'(hq[0].seq); end
            #1;
            chk("R6 busy during walk", int'(busy), 1);
            chk("R7 stall while busy", int'(ren_stall), 1);
            @(posedge clk);
        end
        for (int k = 0; k < pops; k++) begin
            r = hq.pop_back();
            if (r.has) begin
                map_m[r.arch] = r.prevp;
                free_m[r.newp] = 1;
            end
        end
        @(negedge clk); drive_idle();
        #1;
        chk("R6 busy after walk", int'(busy), 0);
        check_common("R6 R8");
        @(posedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < NA; i++) map_m[i] = i;
        for (int i = 0; i < NP; i++) begin rdy_m[i] = 1; free_m[i] = (i >= NA); end
        drive_idle();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R1: identity map, all ready, pool holds the spare registers
        for (int a = 0; a < NA; a++) do_idle(a, "R1");
        chk("R1 busy at reset", int'(busy), 0);

        // R6: squash on an empty log changes nothing
        do_squash(0);

        // R2: allocate every spare register, then R7: pool exhausted
        for (int i = 0; i < NP - NA; i++) do_rename(1, i % NA, "R2");
        do_rename(1, 3, "R7 pool empty");
        // R4: placeholder still accepted without a free register
        do_rename(0, 0, "R4 placeholder");
        do_idle(0, "R4");

        // R5: mismatched commit ignored, then matching commit frees
        do_commit(hq[0].seq + 1, "R5 mismatch");
        do_idle(0, "R5");
        do_commit(hq[0].seq, "R5 match");
        do_idle(1, "R5");

        // R3: ready write on a just-renamed register
        do_rdy(map_m[1]);
        do_idle(1, "R3");

        // R4/R7: fill the log with placeholders until full
        while (hq.size() < HD) do_rename(0, 0, "R4");
        do_rename(0, 2, "R7 log full");

        // R6/R8: partial squash with commit attempts while busy
        do_squash(hq[HD / 2].seq);
        do_squash(hq[0].seq - 1);

        // Random mix
        for (int it = 0; it < 3000; it++) begin
            int op = $urandom % 20;
            if (op < 9) do_rename(($urandom % 4) != 0, $urandom % NA, "R7");
            else if (op < 14) begin
                if (hq.size() > 0 && ($urandom % 5) != 0) do_commit(hq[0].seq, "R5");
                else do_commit(seqc + 3, "R5 stray");
            end
            else if (op < 16) do_rdy($urandom % NP);
            else if (op == 16) begin
                if (hq.size() > 0) do_squash(hq[$urandom % hq.size()].seq);
                else do_squash(seqc - 1);
            end
            else do_idle($urandom % NA, "R3");
        end

        // Drain: commit everything, pool must return to full spare count
        while (hq.size() > 0) do_commit(hq[0].seq, "R5 drain");
        do_idle(0, "R5");
        chk("R5 pool refilled", int'(free_count), NP - NA);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule